// File: doc/BRIEF.md
# Orientation-Quantized Binary Descriptor Rotator

This block turns a raw 256-bit binary feature descriptor into a rotation-normalized one. Each descriptor bit is one intensity comparison between two test locations. The sampling pattern repeats itself every 11.25 degrees, with eight comparisons in each angular step. A feature rotated by a whole number of steps therefore gives the same bits, shifted by a whole number of bytes. The block receives the signed, intensity-weighted moment sums `u` (horizontal) and `v` (vertical) of the feature patch together with the descriptor. It quantizes the direction of the vector (u, v) into one of 32 sector labels, then shifts the descriptor circularly by eight bits per label step.

The direction comes from a lookup and not from trigonometry. Within one quadrant, |v|·2^16 is compared against |u| scaled by fixed-point tangents of the eight sector edges, which lie at odd multiples of 5.625 degrees. The signs of u and v then pick the quadrant offset. The datapath has two register stages and accepts one feature on every clock.

Top module: `desc_rotnorm`

## Requirements
- R1: A synchronous active-low reset clears the output valid flag, the output label and the output descriptor to zero on the next rising clock edge.
- R2: For nonzero moments the label equals round(atan2(v, u) / 11.25 degrees) modulo 32, with the angle taken in [0, 360). Sector edges therefore fall on odd multiples of 5.625 degrees. The label counts counter-clockwise from the positive u axis.
- R3: The four axis directions give fixed labels: positive u gives 0, positive v gives 8, negative u gives 16 and negative v gives 24. Moments whose u and v are both strictly positive give a label from 0 to 8.
- R4: For label n, output descriptor bit i equals input descriptor bit (i + 8·n) mod 256, where bit 0 is the first bit of the string. The lowest 8·n bits thus move to the top end.
- R5: When u and v are both zero, the label is 0 and the descriptor leaves unchanged.
- R6: The output valid flag, label and descriptor appear exactly two clock cycles after the input valid flag. Features presented on consecutive cycles come out on consecutive cycles, in order.
- R7: While no valid result leaves the pipeline, the output label and descriptor hold their previous values, whatever the inputs carry with the valid flag low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| feat_vld_i | input | 1 | Input feature valid |
| mom_u_i | input | MOM_W (24) | Signed horizontal moment sum |
| mom_v_i | input | MOM_W (24) | Signed vertical moment sum |
| desc_i | input | DESC_W (256) | Raw descriptor, bit 0 first |
| feat_vld_o | output | 1 | Output feature valid |
| orient_o | output | 5 | Orientation sector label 0 to 31 |
| desc_o | output | DESC_W (256) | Rotation-normalized descriptor |

## Verification
The assertions assume that the valid input is a plain level sampled on each clock, with no handshake. They also assume that the moments are in two's complement and may take any value, including the most negative one. The bench keeps random moment pairs at least 0.01 of a sector away from any sector edge. A floating-point atan2 reference is then free of the fixed-point tangent rounding of the threshold table. Exact edge and extreme-value behaviour is covered instead by hand-picked table vectors, the four axes and the zero vector.

// File: rtl/desc_rot_pkg.sv
// Package: shared constants for the descriptor rotator.
// Assumes a 32-sector orientation code: the tangent table below holds the
// eight in-quadrant sector edges (odd multiples of 5.625 deg) in unsigned
// fixed point with TAN_FRAC fraction bits.
package desc_rot_pkg;
    localparam int SECTORS  = 32;
    localparam int LAB_W    = $clog2(SECTORS);
    localparam int QSECT    = SECTORS / 4;
    localparam int EDGES    = QSECT;
    localparam int TAN_FRAC = 16;
    localparam int TAN_W    = 20;

    typedef logic [LAB_W-1:0] label_t;

    // tan(5.625), tan(16.875), ... tan(84.375) scaled by 2^16
    localparam logic [TAN_W-1:0] TAN_EDGE [EDGES] = '{
        20'd6455,   20'd19880,  20'd35029,  20'd53784,
        20'd79856,  20'd122609, 20'd216043, 20'd665398
    };
endpackage

// File: rtl/orient_quant.sv
// Module: orient_quant
// Maps signed moments (u, v) to a sector label 0..SECTORS-1 and registers it
// when vld_i is high. It folds the vector into one quadrant: the numerator is
// the component on the counter-clockwise side, the denominator the other one.
// It counts the tangent edges the ratio exceeds, then adds the quadrant offset.
// Assumes two's complement moments; the most negative value is handled.
module orient_quant
    import desc_rot_pkg::*;
#(
    parameter int MOM_W = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    vld_i,
    input  logic signed [MOM_W-1:0] u_i,
    input  logic signed [MOM_W-1:0] v_i,
    output label_t                  lab_o
);
    localparam int PW    = MOM_W + TAN_W;
    localparam int IDX_W = $clog2(EDGES + 1);

    logic             u_neg, v_neg, u_zero, v_zero, both_zero;
    logic [MOM_W-1:0] mag_u, mag_v, num, den;
    logic [1:0]       quad;
    logic [EDGES-1:0] beyond_edge;
    logic [IDX_W-1:0] step_idx;
    label_t           lab_d;

    // Sign, zero and magnitude of each moment
    always_comb begin
        u_neg  = u_i[MOM_W-1];
        v_neg  = v_i[MOM_W-1];
        u_zero = (u_i == '0);
        v_zero = (v_i == '0);
        mag_u  = u_neg ? MOM_W'(-u_i) : MOM_W'(u_i);
        mag_v  = v_neg ? MOM_W'(-v_i) : MOM_W'(v_i);
    end

    // Quadrant selection and folding into a first-quadrant ratio num/den
    always_comb begin
        both_zero = 1'b0;
        quad      = 2'd0;
        num       = mag_v;
        den       = mag_u;
        if (!u_neg && !u_zero && !v_neg) begin
            quad = 2'd0; num = mag_v; den = mag_u;
        end else if ((u_neg || u_zero) && !v_neg && !v_zero) begin
            quad = 2'd1; num = mag_u; den = mag_v;
        end else if (u_neg && (v_neg || v_zero)) begin
            quad = 2'd2; num = mag_v; den = mag_u;
        end else if (!u_neg && v_neg) begin
            quad = 2'd3; num = mag_u; den = mag_v;
        end else begin
            both_zero = 1'b1;
        end
    end

    // One comparator per sector edge: num * 2^F > den * tan(edge)
    for (genvar e = 0; e < EDGES; e++) begin : g_edge
        assign beyond_edge[e] = (PW'(num) << TAN_FRAC) > (PW'(den) * PW'(TAN_EDGE[e]));
    end

    // Count the edges passed; the table is monotonic so this is the step
    always_comb begin
        step_idx = '0;
        for (int e = 0; e < EDGES; e++) begin
            step_idx = step_idx + IDX_W'(beyond_edge[e]);
        end
    end

    // Quadrant offset plus in-quadrant step, wrapping modulo SECTORS
    always_comb begin
        if (both_zero) lab_d = '0;
        else           lab_d = label_t'(int'(quad) * QSECT + int'(step_idx));
    end

    // Label register, loaded only for valid features
    always_ff @(posedge clk) begin
        if (!rst_n)     lab_o <= '0;
        else if (vld_i) lab_o <= lab_d;
    end

    // R3: positive u axis maps to label 0
    a_r3_pos_u_axis: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && v_i == '0 && u_i > 0) |=> (lab_o == '0));

    // R3: positive v axis maps to the quarter-turn label
    a_r3_pos_v_axis: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && u_i == '0 && v_i > 0) |=> (lab_o == label_t'(QSECT)));

    // R3: strictly first-quadrant moments stay within labels 0..QSECT
    a_r3_first_quadrant: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && u_i > 0 && v_i > 0) |=> (lab_o <= label_t'(QSECT)));

    // R5: zero moments yield label 0
    a_r5_zero_label: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && u_i == '0 && v_i == '0) |=> (lab_o == '0));
endmodule

// File: rtl/byte_rotator.sv
// Module: byte_rotator
// Combinational circular shift of the descriptor toward bit 0 by STEP bits
// per label unit: out[i] = in[(i + STEP*n) mod DESC_W]. One log-shifter stage
// per label bit. Assumes STEP * 2^LAB_W equals DESC_W, which makes a full
// turn an identity.
module byte_rotator
    import desc_rot_pkg::*;
#(
    parameter int DESC_W = 256,
    parameter int STEP   = DESC_W / SECTORS
) (
    input  logic [DESC_W-1:0] d_i,
    input  label_t            sh_i,
    output logic [DESC_W-1:0] d_o
);
    logic [DESC_W-1:0] stage [LAB_W+1];

    assign stage[0] = d_i;

    // Stage s rotates by STEP*2^s when label bit s is set
    for (genvar s = 0; s < LAB_W; s++) begin : g_stage
        localparam int K = (STEP << s) % DESC_W;
        assign stage[s+1] = sh_i[s] ? ((stage[s] >> K) | (stage[s] << (DESC_W - K)))
                                    : stage[s];
    end

    assign d_o = stage[LAB_W];
endmodule

// File: rtl/desc_rotnorm.sv
// Module: desc_rotnorm (top)
// Two-stage pipeline. Stage 1 registers the quantized label and the raw
// descriptor. Stage 2 registers the byte-rotated descriptor and the label.
// One feature per cycle, fixed latency of two cycles. Assumes feat_vld_i is
// a level that qualifies the other inputs in the same cycle.
module desc_rotnorm
    import desc_rot_pkg::*;
#(
    parameter int MOM_W  = 24,
    parameter int DESC_W = 256
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    feat_vld_i,
    input  logic signed [MOM_W-1:0] mom_u_i,
    input  logic signed [MOM_W-1:0] mom_v_i,
    input  logic [DESC_W-1:0]       desc_i,
    output logic                    feat_vld_o,
    output logic [LAB_W-1:0]        orient_o,
    output logic [DESC_W-1:0]       desc_o
);
    localparam int STEP = DESC_W / SECTORS;

    logic              s1_vld;
    label_t            s1_lab;
    logic [DESC_W-1:0] s1_desc;
    logic [DESC_W-1:0] rot_desc;

    orient_quant #(.MOM_W(MOM_W)) u_quant (
        .clk   (clk),
        .rst_n (rst_n),
        .vld_i (feat_vld_i),
        .u_i   (mom_u_i),
        .v_i   (mom_v_i),
        .lab_o (s1_lab)
    );

    // Stage 1: valid flag and raw descriptor
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld  <= 1'b0;
            s1_desc <= '0;
        end else begin
            s1_vld <= feat_vld_i;
            if (feat_vld_i) s1_desc <= desc_i;
        end
    end

    byte_rotator #(.DESC_W(DESC_W), .STEP(STEP)) u_rot (
        .d_i  (s1_desc),
        .sh_i (s1_lab),
        .d_o  (rot_desc)
    );

    // Stage 2: output registers, loaded only for valid features
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            feat_vld_o <= 1'b0;
            orient_o   <= '0;
            desc_o     <= '0;
        end else begin
            feat_vld_o <= s1_vld;
            if (s1_vld) begin
                orient_o <= s1_lab;
                desc_o   <= rot_desc;
            end
        end
    end

    // R6: each output valid traces back to a stage-1 valid
    a_r6_out_from_s1: assert property (@(posedge clk) disable iff (!rst_n)
        feat_vld_o |-> $past(s1_vld));

    // R6: each stage-1 valid traces back to an input valid
    a_r6_s1_from_in: assert property (@(posedge clk) disable iff (!rst_n)
        s1_vld |-> $past(feat_vld_i));

    // R4: rotation preserves the number of set bits
    a_r4_ones_kept: assert property (@(posedge clk) disable iff (!rst_n)
        feat_vld_o |-> ($countones(desc_o) == $countones($past(s1_desc))));

    // R5: label 0 passes the descriptor through unchanged
    a_r5_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        (feat_vld_o && orient_o == '0) |-> (desc_o == $past(s1_desc)));

    // R7: outputs hold while nothing valid leaves stage 1
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_vld |=> ($stable(desc_o) && $stable(orient_o)));
endmodule

// File: tb/desc_rotnorm_test.sv
// Bench for desc_rotnorm: table walk, then directed and random tests.
module desc_rotnorm_test;
    localparam int CLK_PERIOD = 10;
    localparam int MOM_W      = 24;
    localparam int DESC_W     = 256;
    localparam int NTAB       = 16;
    localparam int WATCHDOG   = 50000;

    // Table: u, v and expected label (R2 rounding, signs, extremes)
    localparam int TAB_U [NTAB] = '{100, 0, -100, 0, 100, -100, -100, 100,
                                    1000, 1000, 100, 1000, -1000, 1,
                                    -8388608, 8388607};
    localparam int TAB_V [NTAB] = '{0, 100, 0, -100, 100, 100, -100, -100,
                                    97, 100, -1, -100, -1, 1000,
                                    8388607, -8388608};
    localparam int TAB_L [NTAB] = '{0, 8, 16, 24, 4, 12, 20, 28,
                                    0, 1, 0, 31, 16, 8, 12, 28};

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    feat_vld_i = 1'b0;
    logic signed [MOM_W-1:0] mom_u_i = '0;
    logic signed [MOM_W-1:0] mom_v_i = '0;
    logic [DESC_W-1:0]       desc_i = '0;
    logic                    feat_vld_o;
    logic [4:0]              orient_o;
    logic [DESC_W-1:0]       desc_o;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    desc_rotnorm #(.MOM_W(MOM_W), .DESC_W(DESC_W)) uut (
        .clk(clk), .rst_n(rst_n), .feat_vld_i(feat_vld_i),
        .mom_u_i(mom_u_i), .mom_v_i(mom_v_i), .desc_i(desc_i),
        .feat_vld_o(feat_vld_o), .orient_o(orient_o), .desc_o(desc_o)
    );

    function automatic logic [DESC_W-1:0] rand_desc();
        logic [DESC_W-1:0] r;
        for (int w = 0; w < DESC_W/32; w++) r[w*32 +: 32] = $urandom;
        return r;
    endfunction

    // Expected rotation from R4: out[i] = in[(i + 8n) mod 256]
    function automatic logic [DESC_W-1:0] exp_rot(logic [DESC_W-1:0] d, int n);
        logic [DESC_W-1:0] r;
        for (int i = 0; i < DESC_W; i++) r[i] = d[(i + 8*n) % DESC_W];
        return r;
    endfunction

    // Reference label from R2 via atan2; near_edge flags ambiguous angles
    function automatic int ref_label(int u, int v, output bit near_edge);
        real deg, pos, fr;
        int lab;
        deg = $atan2(real'(v), real'(u)) * 180.0 / 3.14159265358979;
        if (deg < 0.0) deg = deg + 360.0;
        pos = deg / 11.25 + 0.5;
        lab = int'($floor(pos));
        fr  = pos - $floor(pos);
        near_edge = (fr < 0.01) || (fr > 0.99);
        return lab % 32;
    endfunction

    task automatic drive(int u, int v, logic [DESC_W-1:0] d);
        feat_vld_i = 1'b1;
        mom_u_i    = MOM_W'(u);
        mom_v_i    = MOM_W'(v);
        desc_i     = d;
    endtask

    task automatic idle_in();
        feat_vld_i = 1'b0;
    endtask

    task automatic check(string req, logic exp_vld, int exp_lab, logic [DESC_W-1:0] exp_d);
        n_checks++;
        if (feat_vld_o !== exp_vld || orient_o !== 5'(exp_lab) || desc_o !== exp_d) begin
            n_fails++;
            $display("FAIL %s: vld=%0b lab=%0d desc=%h expected vld=%0b lab=%0d desc=%h",
                     req, feat_vld_o, orient_o, desc_o, exp_vld, exp_lab, exp_d);
        end
    endtask

    // One isolated feature: drive, wait two edges, compare
    task automatic one_feature(string req, int u, int v, int lab, logic [DESC_W-1:0] d);
        drive(u, v, d);
        @(negedge clk);
        idle_in();
        @(negedge clk);
        check(req, 1'b1, lab, exp_rot(d, lab));
    endtask

    task automatic run_all();
        logic [DESC_W-1:0] d, a, b, c, last_d;
        int lab, last_lab;
        bit near;

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", 1'b0, 0, '0);
        rst_n = 1'b1;

        // R2 and R3: table of vectors
        for (int t = 0; t < NTAB; t++) begin
            @(negedge clk);
            one_feature("R2", TAB_U[t], TAB_V[t], TAB_L[t], rand_desc());
        end

        // R3: axis directions with large magnitudes
        @(negedge clk); one_feature("R3", 5000000, 0, 0, rand_desc());
        @(negedge clk); one_feature("R3", 0, 5000000, 8, rand_desc());
        @(negedge clk); one_feature("R3", -5000000, 0, 16, rand_desc());
        @(negedge clk); one_feature("R3", 0, -5000000, 24, rand_desc());

        // R5: zero moments pass the descriptor through
        d = rand_desc();
        @(negedge clk); one_feature("R5", 0, 0, 0, d);
        n_checks++;
        if (desc_o !== d) begin
            n_fails++;
            $display("FAIL R5: desc=%h expected %h", desc_o, d);
        end

        // R4: every label, vector at the sector centre
        for (int n = 0; n < 32; n++) begin
            real ang;
            ang = real'(n) * 11.25 * 3.14159265358979 / 180.0;
            @(negedge clk);
            one_feature("R4", $rtoi(100000.0 * $cos(ang)), $rtoi(100000.0 * $sin(ang)),
                        n, rand_desc());
        end

        // R2: random pairs against the atan2 reference
        for (int k = 0; k < 200; k++) begin
            int u, v;
            do begin
                u = $signed($urandom) >>> 11;
                v = $signed($urandom) >>> 11;
                lab = ref_label(u, v, near);
            end while (near || (u == 0 && v == 0));
            @(negedge clk);
            one_feature("R2", u, v, lab, rand_desc());
        end

        // R6: three back-to-back features
        a = rand_desc(); b = rand_desc(); c = rand_desc();
        @(negedge clk); drive(100, 0, a);
        @(negedge clk); drive(0, 100, b);
        @(negedge clk); check("R6", 1'b1, 0, exp_rot(a, 0)); drive(-100, -100, c);
        @(negedge clk); check("R6", 1'b1, 8, exp_rot(b, 8)); idle_in();
        @(negedge clk); check("R6", 1'b1, 20, exp_rot(c, 20));
        last_d = exp_rot(c, 20); last_lab = 20;
        @(negedge clk); check("R6", 1'b0, 20, last_d);

        // R7: inputs change with valid low; outputs hold
        for (int k = 0; k < 3; k++) begin
            mom_u_i = MOM_W'(-7 * (k + 1));
            mom_v_i = MOM_W'(3 * (k + 2));
            desc_i  = rand_desc();
            @(negedge clk);
            check("R7", 1'b0, last_lab, last_d);
        end

        // R1: reset in mid-stream clears outputs
        drive(0, -100, rand_desc());
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", 1'b0, 0, '0);
        idle_in();
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 1'b0, 0, '0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (WATCHDOG) @(posedge clk);
                n_checks++;
                n_fails++;
                $display("FAIL watchdog: run did not complete, expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule